// File: doc/BRIEF.md
# Desaturation Fault Supervisor

This block supervises the collector-voltage protection of a single power switch. It sees the drive-on command and the already-digitized output of the desaturation comparator. It closes the blanking-capacitor discharge switch whenever the drive is off, and keeps it closed for a masking window at the start of every on period. Only after that window does it arm detection.

A comparator assertion while armed latches a fault. The latched fault inhibits the drive at once. After a programmable delay it requests a soft shutdown of the gate. After a second, longer delay it pulls the active-low fault output low. The fault is cleared through an active-low clear input that must stay low for a debounce count. Acceptance releases the fault output, but the drive stays inhibited until the clear input returns high. All timings are parameters counted in clock cycles.

Top module: `dsat_supervisor`

## Requirements
- R1: While `drive_on` is 0, `dis_sw_en` is 1.
- R2: After `drive_on` is sampled 1 with no inhibit, `dis_sw_en` stays 1 for `MASK_CYC` rising edges and is 0 from edge `MASK_CYC` onward while the drive stays on.
- R3: `desat_cmp` is ignored while `drive_on` is 0 or while the masking window of R2 is still running; no fault is latched and `drive_inhibit` stays 0.
- R4: `desat_cmp` sampled 1 while armed latches a fault on that edge: from then on `drive_inhibit` is 1 and `dis_sw_en` is 1.
- R5: `soft_off_req` rises `SSD_CYC` edges after the latching edge and stays 1 until the fault is cleared.
- R6: `fault_n` falls `REPORT_CYC` edges after the latching edge and stays 0 until the fault is cleared.
- R7: `clr_n` sampled 0 on `DEB_CYC` consecutive edges is accepted. On the next edge the fault clears, so `fault_n` returns to 1 and `soft_off_req` to 0. A shorter low pulse, or a low period broken by a high sample, is ignored and restarts the count.
- R8: While `clr_n` is 0, `drive_inhibit` is 1, including after the fault has been cleared.
- R9: While the drive is inhibited, neither `drive_on` nor `desat_cmp` has any effect. A desaturation assertion while `clr_n` is held low latches no new fault.
- R10: When `clr_n` goes high with no fault latched, `drive_inhibit` drops in the same cycle, and a fresh masking window per R2 starts if `drive_on` is 1.
- R11: After the synchronous reset `rst_n`, `fault_n` is 1, `soft_off_req` is 0 and `dis_sw_en` is 1. With `clr_n` low, as when left undriven, `drive_inhibit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drive_on | input | 1 | Gate drive command, 1 = on |
| desat_cmp | input | 1 | Digitized desaturation comparator, 1 = over threshold |
| clr_n | input | 1 | Raw active-low fault clear level |
| dis_sw_en | output | 1 | Blanking-capacitor discharge switch, 1 = closed |
| soft_off_req | output | 1 | Soft shutdown request to the output stage |
| fault_n | output | 1 | Active-low fault report |
| drive_inhibit | output | 1 | 1 = gate must be held off |

## Verification
The assertions assume that `clr_n`, `drive_on` and `desat_cmp` are synchronous to `clk` and settle away from its rising edge. They make no assumption about the order of drive and clear events. The bench drives every input on the falling edge and never runs the parameter delays at zero. This keeps each masking, shutdown, report and debounce count observable one edge before and one edge after its expiry.

// File: rtl/dsat_pkg.sv
// Shared helpers for the desaturation supervisor.
// Assumes only integer parameters of zero or more.
package dsat_pkg;
    // Width of a counter that must hold the values 0 to lim.
    function automatic int cnt_w(input int lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction
endpackage

// File: rtl/dsat_delay_cnt.sv
// Counts edges while `active` is high and raises `done` once LIM edges
// have passed. The count holds at LIM and clears when `active` drops.
// Assumes `active` stays high for the whole interval being timed.
module dsat_delay_cnt #(
    parameter int LIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);
    import dsat_pkg::*;
    localparam int W = cnt_w(LIM);
    localparam logic [W-1:0] LIM_V = W'(LIM);

    generate
        if (LIM == 0) begin : g_zero
            assign done = active;
        end else begin : g_cnt
            logic [W-1:0] cnt;
            // Advance the elapsed-edge count, holding at the limit.
            always_ff @(posedge clk) begin
                if (!rst_n || !active) cnt <= '0;
                else if (cnt != LIM_V) cnt <= cnt + 1'b1;
            end
            assign done = active && (cnt == LIM_V);
        end
    endgenerate
endmodule

// File: rtl/dsat_clr_debounce.sv
// Accepts the active-low clear level after DEB_CYC consecutive low samples.
// Any high sample restarts the count. Assumes clr_n is synchronous to clk.
module dsat_clr_debounce #(
    parameter int DEB_CYC = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    output logic accepted
);
    import dsat_pkg::*;
    localparam int W = cnt_w(DEB_CYC);
    localparam logic [W-1:0] LIM_V = W'(DEB_CYC);

    logic [W-1:0] low_cnt;

    // Count consecutive low samples of the clear input.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_n) low_cnt <= '0;
        else if (low_cnt != LIM_V) low_cnt <= low_cnt + 1'b1;
    end

    assign accepted = !clr_n && (low_cnt == LIM_V);
endmodule

// File: rtl/dsat_blank_timer.sv
// Masking window after turn-on: keeps detection disarmed for MASK_CYC
// edges of effective on-time, restarting at every turn-on.
// Assumes eff_on already includes any inhibit.
module dsat_blank_timer #(
    parameter int MASK_CYC = 37
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eff_on,
    output logic armed
);
    logic mask_done;

    dsat_delay_cnt #(.LIM(MASK_CYC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (eff_on),
        .done   (mask_done)
    );

    assign armed = eff_on && mask_done;
endmodule

// File: rtl/dsat_supervisor.sv
// Desaturation fault supervisor. Arms the comparator after the masking
// window, latches a fault, then times a soft shutdown request and the
// active-low fault report. A debounced active-low clear releases the
// fault. Assumes all inputs are synchronous to clk.
module dsat_supervisor #(
    parameter int MASK_CYC   = 37,
    parameter int SSD_CYC    = 20,
    parameter int REPORT_CYC = 100,
    parameter int DEB_CYC    = 70
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_on,
    input  logic desat_cmp,
    input  logic clr_n,
    output logic dis_sw_en,
    output logic soft_off_req,
    output logic fault_n,
    output logic drive_inhibit
);
    logic fault_lat;
    logic clr_ok;
    logic eff_on;
    logic armed;
    logic ssd_done;
    logic rep_done;

    assign drive_inhibit = fault_lat || !clr_n;
    assign eff_on        = drive_on && !drive_inhibit;

    dsat_blank_timer #(.MASK_CYC(MASK_CYC)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .eff_on (eff_on),
        .armed  (armed)
    );

    dsat_clr_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n    (clr_n),
        .accepted (clr_ok)
    );

    // Fault latch: clearing wins; setting needs an armed detector.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_lat <= 1'b0;
        else if (clr_ok) fault_lat <= 1'b0;
        else if (armed && desat_cmp) fault_lat <= 1'b1;
    end

    dsat_delay_cnt #(.LIM(SSD_CYC)) u_ssd (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (fault_lat),
        .done   (ssd_done)
    );

    dsat_delay_cnt #(.LIM(REPORT_CYC)) u_rep (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (fault_lat),
        .done   (rep_done)
    );

    assign dis_sw_en    = !armed;
    assign soft_off_req = ssd_done;
    assign fault_n      = !rep_done;
endmodule

// File: rtl/dsat_supervisor_chk.sv
// Checker for dsat_supervisor, relating its ports over time.
// Assumes the inputs are synchronous to clk.
module dsat_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic drive_on,
    input logic clr_n,
    input logic dis_sw_en,
    input logic soft_off_req,
    input logic fault_n,
    input logic drive_inhibit
);
    a_r1_off_discharge: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_on |-> dis_sw_en);

    a_r2_open_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
        !dis_sw_en |-> (drive_on && !drive_inhibit));

    a_r5_soft_implies_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        soft_off_req |-> drive_inhibit);

    a_r6_report_implies_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> drive_inhibit);

    a_r7_release_under_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> !clr_n);

    a_r8_clear_low_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> drive_inhibit);
endmodule

bind dsat_supervisor dsat_supervisor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .drive_on      (drive_on),
    .clr_n         (clr_n),
    .dis_sw_en     (dis_sw_en),
    .soft_off_req  (soft_off_req),
    .fault_n       (fault_n),
    .drive_inhibit (drive_inhibit)
);

// File: tb/tb_dsat_supervisor.sv
module tb_dsat_supervisor;
    localparam int MASK = 37;
    localparam int SSD  = 20;
    localparam int REP  = 100;
    localparam int DEB  = 70;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drive_on = 1'b0;
    logic desat_cmp = 1'b0;
    logic clr_n = 1'b0;   // models the pull-down: low until driven
    logic dis_sw_en, soft_off_req, fault_n, drive_inhibit;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dsat_supervisor #(
        .MASK_CYC(MASK), .SSD_CYC(SSD), .REPORT_CYC(REP), .DEB_CYC(DEB)
    ) dut (
        .clk(clk), .rst_n(rst_n), .drive_on(drive_on), .desat_cmp(desat_cmp),
        .clr_n(clr_n), .dis_sw_en(dis_sw_en), .soft_off_req(soft_off_req),
        .fault_n(fault_n), .drive_inhibit(drive_inhibit)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R11", "fault_n", fault_n, 1'b1);
        chk("R11", "soft_off_req", soft_off_req, 1'b0);
        chk("R11", "dis_sw_en", dis_sw_en, 1'b1);
        chk("R11", "drive_inhibit", drive_inhibit, 1'b1);
    endtask

    task automatic t_release;
        clr_n = 1'b1;
        #1;
        chk("R10", "inhibit drops", drive_inhibit, 1'b0);
        wait_cyc(1);
    endtask

    task automatic t_mask_and_ignore;
        desat_cmp = 1'b1;
        wait_cyc(5);
        chk("R3", "desat while off ignored", drive_inhibit, 1'b0);
        chk("R1", "switch closed while off", dis_sw_en, 1'b1);
        drive_on = 1'b1;              // desat stays high through mask window
        wait_cyc(MASK - 1);
        chk("R2", "switch closed in mask", dis_sw_en, 1'b1);
        chk("R3", "desat in mask ignored", drive_inhibit, 1'b0);
        desat_cmp = 1'b0;
        wait_cyc(1);
        chk("R2", "switch open after mask", dis_sw_en, 1'b0);
        drive_on = 1'b0;
        #1;
        chk("R1", "switch closes at turn-off", dis_sw_en, 1'b1);
        wait_cyc(1);
    endtask

    task automatic t_fault;
        drive_on = 1'b1;
        wait_cyc(MASK);
        chk("R2", "armed", dis_sw_en, 1'b0);
        desat_cmp = 1'b1;
        wait_cyc(1);
        desat_cmp = 1'b0;
        chk("R4", "inhibit on latch", drive_inhibit, 1'b1);
        chk("R4", "switch closed on latch", dis_sw_en, 1'b1);
        wait_cyc(SSD - 1);
        chk("R5", "soft not yet", soft_off_req, 1'b0);
        wait_cyc(1);
        chk("R5", "soft asserted", soft_off_req, 1'b1);
        wait_cyc(REP - SSD - 1);
        chk("R6", "report not yet", fault_n, 1'b1);
        wait_cyc(1);
        chk("R6", "report asserted", fault_n, 1'b0);
        chk("R9", "drive_on ignored while faulted", dis_sw_en, 1'b1);
        chk("R5", "soft held", soft_off_req, 1'b1);
    endtask

    task automatic t_short_clear;
        clr_n = 1'b0;
        wait_cyc(DEB - 1);
        clr_n = 1'b1;
        wait_cyc(2);
        chk("R7", "short pulse ignored", fault_n, 1'b0);
        clr_n = 1'b0;
        wait_cyc(DEB - 2);
        clr_n = 1'b1;                 // one high sample breaks the count
        wait_cyc(1);
        clr_n = 1'b0;
        wait_cyc(DEB - 2);
        clr_n = 1'b1;
        wait_cyc(2);
        chk("R7", "glitch restarts count", fault_n, 1'b0);
        chk("R7", "soft still held", soft_off_req, 1'b1);
    endtask

    task automatic t_accept_clear;
        clr_n = 1'b0;
        wait_cyc(DEB);
        chk("R7", "fault before acceptance", fault_n, 1'b0);
        wait_cyc(1);
        chk("R7", "fault released", fault_n, 1'b1);
        chk("R7", "soft released", soft_off_req, 1'b0);
        chk("R8", "inhibit while clear low", drive_inhibit, 1'b1);
        desat_cmp = 1'b1;
        wait_cyc(MASK + 10);
        chk("R9", "no relatch under clear", fault_n, 1'b1);
        chk("R9", "no soft under clear", soft_off_req, 1'b0);
        chk("R9", "switch closed under clear", dis_sw_en, 1'b1);
        desat_cmp = 1'b0;
        clr_n = 1'b1;
        #1;
        chk("R10", "inhibit drops on clear high", drive_inhibit, 1'b0);
        wait_cyc(MASK - 1);
        chk("R10", "fresh mask window", dis_sw_en, 1'b1);
        wait_cyc(1);
        chk("R10", "armed after fresh mask", dis_sw_en, 1'b0);
        drive_on = 1'b0;
        wait_cyc(2);
    endtask

    initial begin
        t_reset();
        t_release();
        t_mask_and_ignore();
        t_fault();
        t_short_clear();
        t_accept_clear();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule